// File: doc/BRIEF.md
# Four-Thread Fine-Grained Issue Selector

This block sits in the thread-select stage of a single-issue, in-order, six-stage core pipeline. The stage lies between fetch and decode. In every clock cycle it picks one of four hardware thread contexts to send an instruction down the pipe. Each thread reports whether it has an instruction ready, whether it is held by an outstanding cache miss, and whether its next instruction is a load or a branch. The selector skips any thread that is stalled and hands the issue slot to the eligible thread that was served least recently.

A load or a branch has a short pipeline delay. When a thread issues one, a small per-thread down-counter masks that thread out for the next three cycles, and the other threads cover the gap. A cache-miss stall is a level input. The thread stays out of the rotation until that input drops. The selector drives no valid issue only in a cycle in which all four threads are idle or stalled.

Top module: `thr_issue_sel`

## Requirements
- R1: After reset, all delay counters are clear and thread 0 has first priority. With all four threads eligible, the first grant goes to thread 0.
- R2: A thread is eligible only when its ready bit is 1, its miss-stall bit is 0 and its delay counter is zero. A grant never goes to a thread that is not eligible.
- R3: `issue_vld_o` is 0 exactly when no thread is eligible in that cycle.
- R4: With all threads eligible and no loads or branches, grants rotate 0,1,2,3,0 on consecutive cycles.
- R5: The priority pointer sits just after the last granted thread. The search wraps from thread 3 to thread 0 and skips threads that are not eligible.
- R6: A thread granted while its `thr_lb_i` bit is 1 is not eligible for the next 3 cycles. It becomes eligible again in the 4th cycle after the grant.
- R7: A thread whose miss-stall bit is 1 is not eligible. It can be granted in the same cycle in which that bit returns to 0.
- R8: A thread granted while its `thr_lb_i` bit is 0 is not blocked. If it is the only eligible thread, it is granted on every cycle.
- R9: A `thr_lb_i` bit of a thread that is not granted in that cycle has no effect on that thread's later eligibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_rdy_i | input | NUM_THR (4) | Thread has an instruction ready to issue |
| thr_miss_i | input | NUM_THR (4) | Thread is stalled on a cache miss (level) |
| thr_lb_i | input | NUM_THR (4) | Thread's next instruction is a load or a branch |
| issue_vld_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | TID_W (2) | Thread chosen for this cycle |

## Verification
The case that is hardest to reach from the ports is the one where the delay window and the round-robin pointer interact. A thread masked by a load must come back in exactly the 4th cycle while other threads take the slots in between. The stimulus holds all four threads ready, marks only thread 0's next instruction as a load, and follows the rotation through a full lap so that thread 0 returns at the moment its window closes. A second sequence leaves thread 0 as the only ready thread, which makes the three empty cycles directly visible on `issue_vld_o`.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  // wrap-around increment of a thread index
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/thr_dly_cnt.sv
module thr_dly_cnt #(
  parameter int unsigned DELAY = 3,
  localparam int unsigned CNT_W = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(DELAY);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CNT_W'(DELAY)); // R6
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R6
endmodule

// File: rtl/thr_rr_arb.sv
module thr_rr_arb #(
  parameter int unsigned NUM_THR = 4,
  localparam int unsigned TID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] req_i,
  output logic               gnt_vld_o,
  output logic [TID_W-1:0]   gnt_tid_o
);
  import thr_sel_pkg::*;

  logic [TID_W-1:0] ptr_q;

  // search from pointer, first eligible wins
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_tid_o = '0;
    for (int i = 0; i < int'(NUM_THR); i++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + i) % NUM_THR;
      if (!gnt_vld_o && req_i[idx]) begin
        gnt_vld_o = 1'b1;
        gnt_tid_o = TID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (gnt_vld_o) ptr_q <= TID_W'(wrap_inc(int'(gnt_tid_o), NUM_THR));
  end

  AST_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> gnt_vld_o); // R3
  AST_GNT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> req_i[gnt_tid_o]); // R2
endmodule

// File: rtl/thr_issue_sel.sv
module thr_issue_sel #(
  parameter int unsigned NUM_THR  = 4,
  parameter int unsigned LB_DELAY = 3,
  localparam int unsigned TID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] thr_rdy_i,
  input  logic [NUM_THR-1:0] thr_miss_i,
  input  logic [NUM_THR-1:0] thr_lb_i,
  output logic               issue_vld_o,
  output logic [TID_W-1:0]   issue_tid_o
);
  logic [NUM_THR-1:0] busy;
  logic [NUM_THR-1:0] elig;
  logic [NUM_THR-1:0] load;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign load[g] = issue_vld_o && (issue_tid_o == TID_W'(g)) && thr_lb_i[g];
    thr_dly_cnt #(.DELAY(LB_DELAY)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[g]),
      .busy_o (busy[g])
    );
  end

  assign elig = thr_rdy_i & ~thr_miss_i & ~busy;

  thr_rr_arb #(.NUM_THR(NUM_THR)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (elig),
    .gnt_vld_o (issue_vld_o),
    .gnt_tid_o (issue_tid_o)
  );

  AST_GNT_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> (thr_rdy_i[issue_tid_o] && !thr_miss_i[issue_tid_o])); // R7
  AST_LB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && thr_lb_i[issue_tid_o])
      |=> !(issue_vld_o && issue_tid_o == $past(issue_tid_o))); // R6
  AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load & busy) == '0); // R6
endmodule

// File: tb/thr_issue_sel_test.sv
module thr_issue_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rdy = '0, miss = '0, lb = '0;
  logic       vld;
  logic [1:0] tid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thr_issue_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .thr_rdy_i(rdy), .thr_miss_i(miss),
    .thr_lb_i(lb), .issue_vld_o(vld), .issue_tid_o(tid)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rdy = '0; miss = '0; lb = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle at negedge, check the combinational grant before posedge
  task automatic step(input logic [3:0] r, input logic [3:0] m, input logic [3:0] l,
                      input logic ev, input logic [1:0] et, input string req);
    @(negedge clk);
    rdy = r; miss = m; lb = l;
    #1;
    checks++;
    if (vld !== ev || (ev && tid !== et)) begin
      fails++;
      $display("FAIL %s: vld=%0b tid=%0d expected vld=%0b tid=%0d", req, vld, tid, ev, et);
    end
  endtask

  task automatic t_rotate();
    do_reset();
    step(4'hF, 4'h0, 4'h0, 1, 0, "R1");
    step(4'hF, 4'h0, 4'h0, 1, 1, "R4");
    step(4'hF, 4'h0, 4'h0, 1, 2, "R4");
    step(4'hF, 4'h0, 4'h0, 1, 3, "R4");
    step(4'hF, 4'h0, 4'h0, 1, 0, "R4");
  endtask

  task automatic t_skip();
    do_reset();
    step(4'b1010, 4'h0, 4'h0, 1, 1, "R5");
    step(4'b1010, 4'h0, 4'h0, 1, 3, "R5");
    step(4'b1010, 4'h0, 4'h0, 1, 1, "R5");
    step(4'hF,    4'h0, 4'h0, 1, 2, "R5");
    step(4'h0,    4'h0, 4'h0, 0, 0, "R3");
    step(4'b0001, 4'h0, 4'h0, 1, 0, "R5");
  endtask

  task automatic t_lb_single();
    do_reset();
    step(4'b0001, 4'h0, 4'b0001, 1, 0, "R6");
    step(4'b0001, 4'h0, 4'h0, 0, 0, "R6");
    step(4'b0001, 4'h0, 4'h0, 0, 0, "R6");
    step(4'b0001, 4'h0, 4'h0, 0, 0, "R3");
    step(4'b0001, 4'h0, 4'h0, 1, 0, "R6");
    step(4'b0001, 4'h0, 4'h0, 1, 0, "R8");
    step(4'b0001, 4'h0, 4'h0, 1, 0, "R8");
  endtask

  task automatic t_lb_mixed();
    do_reset();
    step(4'hF, 4'h0, 4'b0001, 1, 0, "R6");
    step(4'hF, 4'h0, 4'h0,    1, 1, "R6");
    step(4'hF, 4'h0, 4'h0,    1, 2, "R6");
    step(4'hF, 4'h0, 4'h0,    1, 3, "R6");
    step(4'hF, 4'h0, 4'h0,    1, 0, "R6");
  endtask

  task automatic t_lb_ignored();
    do_reset();
    step(4'hF,    4'h0, 4'b1110, 1, 0, "R9");
    step(4'b0010, 4'h0, 4'h0,    1, 1, "R9");
    step(4'b0100, 4'h0, 4'h0,    1, 2, "R9");
    step(4'b1000, 4'h0, 4'h0,    1, 3, "R9");
  endtask

  task automatic t_miss();
    do_reset();
    step(4'hF, 4'b0001, 4'h0, 1, 1, "R7");
    step(4'hF, 4'hF,    4'h0, 0, 0, "R7");
    step(4'hF, 4'b1011, 4'h0, 1, 2, "R7");
    step(4'hF, 4'b0011, 4'h0, 1, 3, "R7");
    step(4'hF, 4'h0,    4'h0, 1, 0, "R7");
    step(4'b0010, 4'b0010, 4'h0, 0, 0, "R2");
  endtask

  initial begin
    t_rotate();
    t_skip();
    t_lb_single();
    t_lb_mixed();
    t_lb_ignored();
    t_miss();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule